// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the transmit half of an Ethernet MAC's DMA engine. Software places two-word descriptors in a ring in local memory. Each descriptor points at a buffer and describes it. Software then pulses a start command. The engine walks the ring from its current position and reads every buffer it names. It sends the bytes out one at a time on a byte stream and marks the end of each frame. When a frame is finished, the engine hands the frame's first descriptor back to software, raises a sticky completion flag, and halts at the descriptor that follows.

A frame may span any number of descriptors. The descriptor that carries the last-buffer flag ends the frame. A descriptor whose used flag is clear belongs to the engine. If the engine reaches a descriptor that software still owns before the frame has ended, it stops there and raises an error flag. Local memory is reached through a simple word port that never stalls and returns read data one cycle after the request.

Top module: `txdesc_ring_reader`

## Requirements
- R1: After reset the engine is idle. `tx_busy`, `byte_valid`, `frame_end`, `mem_req`, `cmp_flag` and `used_err_flag` are all 0.
- R2: A pulse on `tx_start` is accepted only while the engine is idle and `tx_en` is 1. Otherwise it has no effect: no memory request and no bytes.
- R3: A descriptor occupies 8 bytes. The word at offset 0 holds the buffer byte address, whose two low bits are ignored. The word at offset 4 holds the status: the length in bits [LW-1:0], the last-buffer flag in bit 15, the wrap flag in bit 30 and the used flag in bit 31. Without wrap, the next descriptor follows at +8.
- R4: Each buffer gives exactly its length in bytes, in ascending address order, one per cycle with `byte_valid` high. Within a 32-bit word the byte in bits [7:0] comes first.
- R5: A descriptor whose length is 0 adds no bytes, and the frame carries on with the next descriptor.
- R6: After the last byte of the descriptor that has the last-buffer flag, `frame_end` pulses for one cycle, and never in a cycle where `byte_valid` is high.
- R7: A descriptor with the wrap flag set sends the next fetch to `ring_base`.
- R8: When a frame completes, the engine writes back the status word of the frame's first descriptor, unchanged except that the used flag is set. No other descriptor is written.
- R9: `cmp_flag` sets when a frame completes and stays set until software writes 1 to `stat_clr[0]`. `stat_clr[1]` leaves it alone.
- R10: If the engine reads a descriptor whose used flag is set, it stops without `frame_end` or write-back and sets `used_err_flag`. The flag stays set until software writes 1 to `stat_clr[1]`.
- R11: After a frame, or after a used-flag stop, the engine halts at the descriptor where it stopped. The next accepted start resumes from there.
- R12: While the engine is idle and `tx_en` is 0, the descriptor pointer reloads from `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable; when low and idle, the pointer returns to ring_base |
| tx_start | input | 1 | Start command pulse |
| ring_base | input | AW | Byte address of descriptor 0 |
| stat_clr | input | 2 | Write-1-to-clear: bit 0 completion, bit 1 used-flag error |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| byte_valid | output | 1 | byte_data carries a frame byte |
| byte_data | output | 8 | Frame byte |
| frame_end | output | 1 | One-cycle pulse after the last byte of a frame |
| tx_busy | output | 1 | Engine is walking the ring |
| cmp_flag | output | 1 | Sticky frame-complete flag |
| used_err_flag | output | 1 | Sticky flag: a used descriptor was reached |

## Verification
The bench fills each buffer with a byte pattern that depends on the address. Any skipped, repeated or reordered byte, or a wrong buffer base, therefore shows up in the captured stream. The frames tried are a single five-byte buffer, a single one-byte buffer, and a three-descriptor frame. That frame has a buffer address whose low bits are nonzero, an empty buffer, and a buffer that crosses a word boundary. Between them these separate correct length counting and lane order from errors in address masking or in skipping empty descriptors. A wrap descriptor followed by a frame at slot 0 shows that the wrap flag is honoured. A frame cut short by a used descriptor shows that the error path writes nothing back, and that the engine resumes from the descriptor where it stopped. A start with transmit disabled, a change of ring_base, and each clear bit on its own cover the gating and the sticky flags.

// File: rtl/txring_pkg.sv
// Package: descriptor field positions and the engine state type.
// Assumes the length field is narrower than the last-buffer bit position.
package txring_pkg;
    localparam int WORD_W   = 32;
    localparam int LAST_BIT = 15;
    localparam int WRAP_BIT = 30;
    localparam int USED_BIT = 31;

    typedef enum logic [3:0] {
        ST_IDLE, ST_D0, ST_D1, ST_CHK, ST_RDW, ST_CAP, ST_BYTE, ST_NEXT, ST_WB
    } tx_state_e;
endpackage

// File: rtl/txring_lane.sv
// Byte lane selector: holds one fetched memory word and presents the byte
// picked by the lane index. Lane 0 is bits [7:0].
module txring_lane (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] word_in,
    input  logic [1:0]  lane,
    output logic [7:0]  byte_out
);
    logic [31:0] word_q;

    // Capture the word when the fetch engine asks for it.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= word_in;
    end

    // Pick the current lane.
    always_comb begin
        byte_out = word_q[8*lane +: 8];
    end
endmodule

// File: rtl/txring_status.sv
// Sticky status flags with write-1-to-clear. A set in the same cycle as a
// clear wins, so no event is lost.
module txring_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_err,
    input  logic [1:0] clr,
    output logic       cmp_flag,
    output logic       err_flag
);
    // Completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_flag <= 1'b0;
        else if (set_done) cmp_flag <= 1'b1;
        else if (clr[0])   cmp_flag <= 1'b0;
    end

    // Used-descriptor error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (set_err) err_flag <= 1'b1;
        else if (clr[1])  err_flag <= 1'b0;
    end

    p_clear_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !set_done) |=> !cmp_flag);
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !clr[0]) |=> cmp_flag);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr[1]) |=> err_flag);
endmodule

// File: rtl/txring_fetch.sv
// Descriptor walker: fetches descriptors, reads their buffers word by word,
// steps the byte lane, and writes back the first descriptor's status.
// Assumes memory never stalls and returns read data one cycle after the
// request, and that ring_base is 8-byte aligned.
module txring_fetch
    import txring_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          tx_start,
    input  logic [AW-1:0] ring_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          load_word,
    output logic [1:0]    lane,
    output logic          byte_valid,
    output logic          frame_done,
    output logic          used_hit,
    output logic          busy
);
    localparam logic [AW-1:0] DESC_STEP = AW'(8);
    localparam logic [AW-1:0] WORD_STEP = AW'(4);
    localparam logic [LW-1:0] ONE_LEFT  = LW'(1);

    tx_state_e     state_q;
    logic [AW-1:0] desc_q, next_q, buf_q, first_addr_q;
    logic [31:0]   first_stat_q;
    logic [LW-1:0] rem_q;
    logic [1:0]    lane_q;
    logic          first_q, last_q;

    // Main sequencer: walks descriptors and buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            desc_q       <= ring_base;
            next_q       <= '0;
            buf_q        <= '0;
            first_addr_q <= '0;
            first_stat_q <= '0;
            rem_q        <= '0;
            lane_q       <= '0;
            first_q      <= 1'b1;
            last_q       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!tx_en) desc_q <= ring_base;
                    if (tx_en && tx_start) begin
                        first_q <= 1'b1;
                        state_q <= ST_D0;
                    end
                end
                ST_D0: state_q <= ST_D1;
                ST_D1: begin
                    buf_q   <= mem_rdata[AW-1:0] & ~AW'(3);
                    state_q <= ST_CHK;
                end
                ST_CHK: begin
                    if (mem_rdata[USED_BIT]) begin
                        state_q <= ST_IDLE;
                    end else begin
                        if (first_q) begin
                            first_addr_q <= desc_q;
                            first_stat_q <= mem_rdata;
                        end
                        last_q  <= mem_rdata[LAST_BIT];
                        next_q  <= mem_rdata[WRAP_BIT] ? ring_base : desc_q + DESC_STEP;
                        rem_q   <= mem_rdata[LW-1:0];
                        state_q <= (mem_rdata[LW-1:0] == '0) ? ST_NEXT : ST_RDW;
                    end
                end
                ST_RDW: state_q <= ST_CAP;
                ST_CAP: begin
                    lane_q  <= 2'd0;
                    state_q <= ST_BYTE;
                end
                ST_BYTE: begin
                    rem_q <= rem_q - ONE_LEFT;
                    if (rem_q == ONE_LEFT) begin
                        state_q <= ST_NEXT;
                    end else if (lane_q == 2'd3) begin
                        buf_q   <= buf_q + WORD_STEP;
                        state_q <= ST_RDW;
                    end else begin
                        lane_q  <= lane_q + 2'd1;
                    end
                end
                ST_NEXT: begin
                    desc_q  <= next_q;
                    first_q <= 1'b0;
                    state_q <= last_q ? ST_WB : ST_D0;
                end
                ST_WB: begin
                    first_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_D0:  begin mem_req = 1'b1; mem_addr = desc_q; end
            ST_D1:  begin mem_req = 1'b1; mem_addr = desc_q + WORD_STEP; end
            ST_RDW: begin mem_req = 1'b1; mem_addr = buf_q; end
            ST_WB:  begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_addr_q + WORD_STEP;
                mem_wdata = first_stat_q | (32'd1 << USED_BIT);
            end
            default: ;
        endcase
    end

    // Strobes for the lane, the stream and the status flags.
    always_comb begin
        load_word  = (state_q == ST_CAP);
        lane       = lane_q;
        byte_valid = (state_q == ST_BYTE);
        frame_done = (state_q == ST_WB);
        used_hit   = (state_q == ST_CHK) && mem_rdata[USED_BIT];
        busy       = (state_q != ST_IDLE);
    end

    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(tx_en && tx_start)) |=> !mem_req);
    p_wb_used_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[USED_BIT] && mem_addr == first_addr_q + WORD_STEP));
    p_used_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        used_hit |=> (!busy && $stable(desc_q)));
endmodule

// File: rtl/txdesc_ring_reader.sv
// Top: transmit descriptor ring reader. Joins the descriptor walker, the
// byte lane and the sticky status flags. Assumes a non-stalling memory with
// one-cycle read latency.
module txdesc_ring_reader #(
    parameter int AW = 32,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          tx_start,
    input  logic [AW-1:0] ring_base,
    input  logic [1:0]    stat_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          byte_valid,
    output logic [7:0]    byte_data,
    output logic          frame_end,
    output logic          tx_busy,
    output logic          cmp_flag,
    output logic          used_err_flag
);
    logic       load_word, used_hit;
    logic [1:0] lane;

    txring_fetch #(.AW(AW), .LW(LW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start),
        .ring_base(ring_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .load_word(load_word), .lane(lane), .byte_valid(byte_valid),
        .frame_done(frame_end), .used_hit(used_hit), .busy(tx_busy)
    );

    txring_lane u_lane (
        .clk(clk), .rst_n(rst_n), .load(load_word), .word_in(mem_rdata),
        .lane(lane), .byte_out(byte_data)
    );

    txring_status u_status (
        .clk(clk), .rst_n(rst_n), .set_done(frame_end), .set_err(used_hit),
        .clr(stat_clr), .cmp_flag(cmp_flag), .err_flag(used_err_flag)
    );

    p_end_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && frame_end));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (!mem_req && !byte_valid));
    p_done_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> cmp_flag);
endmodule

// File: tb/sim_txdesc_ring_reader.sv
module sim_txdesc_ring_reader;
    localparam logic [31:0] USED = 32'h8000_0000;
    localparam logic [31:0] WRAP = 32'h4000_0000;
    localparam logic [31:0] LAST = 32'h0000_8000;

    logic        clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, tx_start = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic [1:0]  stat_clr = 2'b00;
    logic        mem_req, mem_we, byte_valid, frame_end, tx_busy, cmp_flag, used_err_flag;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  byte_data;

    logic [31:0] mem [0:255];
    logic [7:0]  got [0:63];
    int gcnt = 0, fe_cnt = 0, req_cnt = 0;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    txdesc_ring_reader u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start),
        .ring_base(ring_base), .stat_clr(stat_clr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_end(frame_end), .tx_busy(tx_busy), .cmp_flag(cmp_flag),
        .used_err_flag(used_err_flag)
    );

    // Memory model: one-cycle read latency, writes take effect at the edge.
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else if (mem_req)      mem_rdata <= mem[mem_addr[9:2]];
    end

    // Stream monitor.
    always @(negedge clk) begin
        if (byte_valid) begin
            if (gcnt < 64) got[gcnt] = byte_data;
            gcnt = gcnt + 1;
        end
        if (frame_end) fe_cnt = fe_cnt + 1;
        if (mem_req) req_cnt = req_cnt + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 3));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int base, input int slot, input int baddr, input logic [31:0] stat);
        mem[(base + slot * 8) >> 2]     = baddr;
        mem[(base + slot * 8 + 4) >> 2] = stat;
    endtask

    task automatic clear_mon();
        gcnt = 0; fe_cnt = 0; req_cnt = 0;
    endtask

    task automatic pulse_start();
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic run_frame();
        clear_mon();
        pulse_start();
        for (int i = 0; i < 2000 && tx_busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // Compare the captured stream to a list of start addresses and lengths.
    task automatic check_bytes(input string tag, input int a0, input int n0, input int a1, input int n1);
        int k = 0;
        check(gcnt == n0 + n1, {tag, " count"}, gcnt, n0 + n1);
        for (int i = 0; i < n0; i++) begin
            check(got[k] == pat(a0 + i), {tag, " byte"}, got[k], pat(a0 + i));
            k++;
        end
        for (int i = 0; i < n1; i++) begin
            check(got[k] == pat(a1 + i), {tag, " byte"}, got[k], pat(a1 + i));
            k++;
        end
    endtask

    task automatic t_reset();
        check(!tx_busy && !byte_valid && !frame_end && !mem_req, "R1 idle outputs", tx_busy, 0);
        check(!cmp_flag && !used_err_flag, "R1 flags", {cmp_flag, used_err_flag}, 0);
    endtask

    task automatic t_single();
        put_desc(32'h100, 0, 32'h200, LAST | 32'd5);
        run_frame();
        check_bytes("R4 single", 32'h200, 5, 0, 0);
        check(fe_cnt == 1, "R6 frame_end", fe_cnt, 1);
        check(cmp_flag, "R9 complete", cmp_flag, 1);
        check(mem[(32'h104) >> 2] == (USED | LAST | 32'd5), "R8 writeback",
              mem[32'h104 >> 2], USED | LAST | 32'd5);
    endtask

    task automatic t_multi();
        put_desc(32'h100, 1, 32'h243, 32'd3);
        put_desc(32'h100, 2, 32'h280, 32'd0);
        put_desc(32'h100, 3, 32'h2C0, LAST | 32'd6);
        clear_mon();
        repeat (20) @(negedge clk);
        check(gcnt == 0 && req_cnt == 0, "R11 halted", req_cnt, 0);
        run_frame();
        check_bytes("R3 R5 multi", 32'h240, 3, 32'h2C0, 6);
        check(fe_cnt == 1, "R6 one end", fe_cnt, 1);
        check(mem[32'h10C >> 2] == (USED | 32'd3), "R8 first used", mem[32'h10C >> 2], USED | 3);
        check(mem[32'h114 >> 2] == 32'd0, "R8 middle untouched", mem[32'h114 >> 2], 0);
        check(mem[32'h11C >> 2] == (LAST | 32'd6), "R8 last untouched", mem[32'h11C >> 2], LAST | 6);
    endtask

    task automatic t_wrap();
        put_desc(32'h100, 4, 32'h300, LAST | WRAP | 32'd2);
        run_frame();
        check_bytes("R7 wrap desc", 32'h300, 2, 0, 0);
        put_desc(32'h100, 0, 32'h210, LAST | 32'd4);
        run_frame();
        check_bytes("R7 wrapped to base", 32'h210, 4, 0, 0);
    endtask

    task automatic t_gate();
        tx_en = 1'b0;
        @(negedge clk);
        clear_mon();
        pulse_start();
        repeat (20) @(negedge clk);
        check(req_cnt == 0 && gcnt == 0 && !tx_busy, "R2 start ignored", req_cnt, 0);
    endtask

    task automatic t_rebase();
        ring_base = 32'h180;
        put_desc(32'h180, 0, 32'h220, LAST | 32'd1);
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        run_frame();
        check_bytes("R12 new base", 32'h220, 1, 0, 0);
    endtask

    task automatic t_clear();
        stat_clr = 2'b10;
        @(negedge clk);
        stat_clr = 2'b00;
        check(cmp_flag, "R9 other clear bit", cmp_flag, 1);
        stat_clr = 2'b01;
        @(negedge clk);
        stat_clr = 2'b00;
        check(!cmp_flag, "R9 cleared", cmp_flag, 0);
    endtask

    task automatic t_used_err();
        put_desc(32'h180, 1, 32'h230, 32'd2);
        put_desc(32'h180, 2, 32'h238, USED | LAST | 32'd1);
        run_frame();
        check_bytes("R10 partial", 32'h230, 2, 0, 0);
        check(used_err_flag, "R10 error flag", used_err_flag, 1);
        check(fe_cnt == 0 && !cmp_flag, "R10 no end", fe_cnt, 0);
        check(mem[32'h18C >> 2] == 32'd2, "R10 no writeback", mem[32'h18C >> 2], 2);
        stat_clr = 2'b10;
        @(negedge clk);
        stat_clr = 2'b00;
        check(!used_err_flag, "R10 cleared", used_err_flag, 0);
        mem[32'h194 >> 2] = LAST | 32'd1;
        run_frame();
        check_bytes("R11 resume", 32'h238, 1, 0, 0);
        check(mem[32'h194 >> 2] == (USED | LAST | 32'd1), "R11 resume writeback",
              mem[32'h194 >> 2], USED | LAST | 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {pat(i * 4 + 3), pat(i * 4 + 2), pat(i * 4 + 1), pat(i * 4)};
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        tx_en = 1'b1;
        @(negedge clk);
        t_single();
        t_multi();
        t_wrap();
        t_gate();
        t_rebase();
        t_clear();
        t_used_err();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule